// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. A global history register holds the outcomes of the most recently resolved branches, whichever branches they were. The predictor table is indexed by the low word-address bits of the branch PC. Each row holds one saturating counter for every possible history value. A lookup combines the PC-selected row with the current history to pick one counter. The prediction is that counter's top bit, and it is returned in the same cycle.

When a branch resolves, the pipeline presents its PC, its actual outcome and the history snapshot that was read out at lookup time. The counter that made the prediction is stepped one count toward the outcome. The outcome is also shifted into the global history. Because the snapshot travels with the branch, training lands on the right counter even if other branches resolved in between.

Each counter behaves as a small state machine. Its states run from strongly not taken (all zeros) up to strongly taken (all ones). Three transitions are possible on a training update:
- count-up, on a taken outcome;
- count-down, on a not-taken outcome;
- hold, when the counter is already saturated in the direction of the outcome, or when it is not addressed.

For the default two-bit counter the states are strong-NT (00), weak-NT (01), weak-T (10) and strong-T (11).

Top module: `cbp_predictor`

## Requirements
- R1: After reset every counter is in its all-zeros state, so every lookup predicts not taken, and the history output `lk_hist` is zero.
- R2: A cycle with `up_valid` high shifts `up_taken` (1 = taken) into bit 0 of the history on the next clock edge, and moves the older bits up by one. The oldest bit is dropped.
- R3: The history is unchanged in any cycle without `up_valid`.
- R4: A lookup selects its counter from two fields. The row is `lk_pc[IDX_W+1:2]`, with IDX_W = log2(ENTRIES). Within the row, the counter is chosen by the current `lk_hist`. PC bits 1:0 and PC bits above the index field have no effect on the prediction.
- R5: The prediction is the top bit of the selected counter. With CTR_W = 2, states 00 and 01 predict not taken, and states 10 and 11 predict taken. From reset, two taken trainings are needed before the counter predicts taken.
- R6: A training step moves the counter one count toward the outcome, and it saturates at all-ones and all-zeros. With CTR_W = 2, a counter trained taken five times still needs two not-taken trainings before it predicts not taken.
- R7: Training addresses exactly one counter: the row from `up_pc[IDX_W+1:2]` and the history `up_hist`. It does not use the current history. The counters of other history values and other rows are unchanged.
- R8: The lookup is combinational and counters change only at the clock edge. A lookup in the same cycle as an update of the same counter therefore returns the value from before the update. A lookup whose PC is held across a cycle with no update returns the same prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | PC of the branch being looked up |
| lk_taken | output | 1 | Prediction: 1 = taken |
| lk_hist | output | HIST_W | Current global history, to be carried with the branch |
| up_valid | input | 1 | A resolved branch is presented for training |
| up_pc | input | PC_W | PC of the resolved branch |
| up_hist | input | HIST_W | History snapshot taken when that branch was looked up |
| up_taken | input | 1 | Actual outcome: 1 = taken |

## Verification
The prediction is combinational. It is checked in the same cycle the lookup PC is driven, a couple of nanoseconds after the falling edge and before the next rising edge, so it always reflects the counters before any update presented in that cycle. A training update and its history shift take effect at the next rising edge. Both are therefore checked one cycle later, by sampling `lk_hist`, or the prediction of the trained counter, just after that edge. A multi-step counter walk re-establishes a known history with untrained updates before each readout, so every readout addresses the intended counter.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
    // Step applied to one saturating counter in a cycle
    typedef enum logic [1:0] {
        CTR_HOLD = 2'b00,
        CTR_UP   = 2'b01,
        CTR_DOWN = 2'b10
    } ctr_op_e;
endpackage

// File: rtl/cbp_hist.sv
module cbp_hist #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;
    logic [HIST_W:0]   widened;

    always_comb begin
        widened = {hist_q, bit_in};
        hist_d  = shift_en ? widened[HIST_W-1:0] : hist_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign hist = hist_q;
endmodule

// File: rtl/cbp_ctr.sv
module cbp_ctr
    import cbp_pkg::*;
#(
    parameter int CTR_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic train,
    input  logic outcome,
    output logic predict
);
    localparam logic [CTR_W-1:0] CTR_MAX = '1;

    logic [CTR_W-1:0] state_q;
    logic [CTR_W-1:0] state_d;
    ctr_op_e          op;

    always_comb begin
        op = CTR_HOLD;
        if (train) begin
            if (outcome && state_q != CTR_MAX)     op = CTR_UP;
            else if (!outcome && state_q != '0)    op = CTR_DOWN;
        end
    end

    always_comb begin
        unique case (op)
            CTR_UP:   state_d = state_q + 1'b1;
            CTR_DOWN: state_d = state_q - 1'b1;
            default:  state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign predict = state_q[CTR_W-1];
endmodule

// File: rtl/cbp_predictor.sv
module cbp_predictor #(
    parameter int ENTRIES = 16,
    parameter int HIST_W  = 2,
    parameter int CTR_W   = 2,
    parameter int PC_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic [HIST_W-1:0] up_hist,
    input  logic              up_taken
);
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int WAYS   = 1 << HIST_W;
    localparam int SLOTS  = ENTRIES * WAYS;
    localparam int SLOT_W = IDX_W + HIST_W;

    logic [HIST_W-1:0] hist;
    logic [SLOT_W-1:0] lk_slot;
    logic [SLOT_W-1:0] up_slot;
    logic [SLOTS-1:0]  slot_pred;

    cbp_hist #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .bit_in   (up_taken),
        .hist     (hist)
    );

    assign lk_slot = {lk_pc[IDX_W+1:2], hist};
    assign up_slot = {up_pc[IDX_W+1:2], up_hist};

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        cbp_ctr #(.CTR_W(CTR_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .train   (up_valid && (up_slot == SLOT_W'(k))),
            .outcome (up_taken),
            .predict (slot_pred[k])
        );
    end

    assign lk_taken = slot_pred[lk_slot];
    assign lk_hist  = hist;
endmodule

// File: rtl/cbp_predictor_chk.sv
module cbp_predictor_chk #(
    parameter int HIST_W = 2,
    parameter int PC_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   lk_pc,
    input logic              lk_taken,
    input logic [HIST_W-1:0] lk_hist,
    input logic              up_valid,
    input logic              up_taken
);
    assert_reset_nt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!lk_taken && lk_hist == '0));

    assert_hist_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> lk_hist == HIST_W'({$past(lk_hist), $past(up_taken)}));

    assert_hist_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(lk_hist));

    // R8: with no update in the previous cycle and the same PC, prediction holds
    assert_pred_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(up_valid) && $stable(lk_pc) && !$rose(rst_n)) |-> $stable(lk_taken));
endmodule

bind cbp_predictor cbp_predictor_chk #(.HIST_W(HIST_W), .PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_pc    (lk_pc),
    .lk_taken (lk_taken),
    .lk_hist  (lk_hist),
    .up_valid (up_valid),
    .up_taken (up_taken)
);

// File: tb/sim_cbp_predictor.sv
module sim_cbp_predictor;
    localparam int HW = 2;
    localparam int PW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] lk_pc = '0;
    logic          lk_taken;
    logic [HW-1:0] lk_hist;
    logic          up_valid = 1'b0;
    logic [PW-1:0] up_pc = '0;
    logic [HW-1:0] up_hist = '0;
    logic          up_taken = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cbp_predictor #(.ENTRIES(16), .HIST_W(HW), .CTR_W(2), .PC_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hist(lk_hist),
        .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken)
    );

    typedef struct packed {
        logic       uv;
        logic [7:0] uword;
        logic [1:0] uh;
        logic       ut;
        logic [7:0] lword;
        logic       exp_lk;
        logic [1:0] exp_hist;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'd3, 2'd0, 1'b1, 8'd3,  1'b0, 2'd1},
        '{1'b1, 8'd3, 2'd0, 1'b1, 8'd3,  1'b0, 2'd3},
        '{1'b0, 8'd0, 2'd0, 1'b0, 8'd3,  1'b0, 2'd3},
        '{1'b1, 8'd3, 2'd3, 1'b1, 8'd5,  1'b0, 2'd3},
        '{1'b1, 8'd3, 2'd3, 1'b1, 8'd3,  1'b0, 2'd3},
        '{1'b0, 8'd0, 2'd0, 1'b0, 8'd3,  1'b1, 2'd3},
        '{1'b1, 8'd3, 2'd3, 1'b0, 8'd3,  1'b1, 2'd2},
        '{1'b1, 8'd7, 2'd2, 1'b0, 8'd3,  1'b0, 2'd0},
        '{1'b0, 8'd0, 2'd0, 1'b0, 8'd3,  1'b1, 2'd0},
        '{1'b0, 8'd0, 2'd0, 1'b0, 8'd19, 1'b1, 2'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic train(input logic [7:0] word, input logic [1:0] h, input logic t);
        @(negedge clk);
        up_valid = 1'b1; up_pc = {22'd0, word, 2'b00}; up_hist = h; up_taken = t;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic zero_hist();
        train(8'd10, 2'd1, 1'b0);
        train(8'd10, 2'd1, 1'b0);
    endtask

    task automatic read_pred(input logic [31:0] pc, output logic p);
        @(negedge clk);
        lk_pc = pc;
        #2 p = lk_taken;
    endtask

    initial begin
        logic p;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #2;
        // R1: reset state
        check("R1 hist", 32'(lk_hist), 32'd0);
        for (int w = 0; w < 16; w++) begin
            lk_pc = 32'(w) << 2;
            #1 check("R1 pred", 32'(lk_taken), 32'd0);
        end

        // vector table: R2 R3 R4 R5 R7 R8
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            up_valid = VECS[i].uv;
            up_pc    = {22'd0, VECS[i].uword, 2'b00};
            up_hist  = VECS[i].uh;
            up_taken = VECS[i].ut;
            lk_pc    = {22'd0, VECS[i].lword, 2'b00};
            #2 check($sformatf("R8/R5/R7/R4 vec%0d pred", i), 32'(lk_taken), 32'(VECS[i].exp_lk));
            @(posedge clk);
            #2 check($sformatf("R2/R3 vec%0d hist", i), 32'(lk_hist), 32'(VECS[i].exp_hist));
        end
        @(negedge clk) up_valid = 1'b0;

        // R4: low PC offset bits ignored (entry 3, hist 0 is weak-T)
        read_pred({22'd0, 8'd3, 2'b11}, p);
        check("R4 offset bits", 32'(p), 32'd1);

        // R6: saturation walk on entry 9, history 0
        for (int k = 0; k < 5; k++) train(8'd9, 2'd0, 1'b1);
        zero_hist();
        read_pred(32'd9 << 2, p);
        check("R6 strong taken", 32'(p), 32'd1);
        train(8'd9, 2'd0, 1'b0);
        zero_hist();
        read_pred(32'd9 << 2, p);
        check("R6 one NT after saturate", 32'(p), 32'd1);
        train(8'd9, 2'd0, 1'b0);
        zero_hist();
        read_pred(32'd9 << 2, p);
        check("R6 two NT after saturate", 32'(p), 32'd0);

        // R7: other history of entry 9 untouched (hist 01)
        train(8'd9, 2'd0, 1'b1);
        train(8'd9, 2'd0, 1'b1);
        zero_hist();
        train(8'd10, 2'd1, 1'b1);
        read_pred(32'd9 << 2, p);
        check("R7 hist01 untrained", 32'(p), 32'd0);
        check("R2 hist after T", 32'(lk_hist), 32'd1);

        // R1: reset mid-run clears counters and history
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        lk_pc = 32'd3 << 2;
        #2 check("R1 re-reset pred", 32'(lk_taken), 32'd0);
        check("R1 re-reset hist", 32'(lk_hist), 32'd0);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule